// File: doc/BRIEF.md
# Dual-Bank GPIO Controller with Atomic Set/Clear Writes

This block controls 32 general-purpose pins through a 256-byte, 32-bit register window. The pins form two banks of 16: pins 0-15 answer at bank base 0x00 and pins 16-31 at bank base 0x80. Each bank holds six per-pin feature bits: output level, output enable, open-drain, pull-up, pull-down and input enable.

Software changes a feature with a single write and never reads it first. The lower half of the written word names pins to switch on and the upper half names pins to switch off. A level read-back register returns the synchronized pin inputs. The pad-side outputs (drive level, drive enable, pull-up and pull-down) come straight from the stored state.

Top module: `gpio_atomic_ctrl`

## Requirements
- R1: Address bit 7 selects the bank (0 gives pins 0-15, 1 gives pins 16-31) and bits [6:0] select the register inside the bank. Bank pin k is chip pin 16*bank+k.
- R2: A write sets the addressed feature of bank pin k when bit k of the word is 1. The offsets are: output level 0x00, output enable 0x04, open-drain 0x08, pull-up 0x18, pull-down 0x1C, input enable 0x20.
- R3: A write clears bank pin k when bit k+16 is 1. When bits k and k+16 are both 1, the pin ends up cleared.
- R4: A pin whose two bits in a write are both 0 keeps its stored value. With no write, no stored value changes.
- R5: Reading offset 0x04, 0x08, 0x18, 0x1C or 0x20 returns the stored bits in [15:0] and their bitwise complement in [31:16].
- R6: Reading offset 0x30 returns, in bit k, the bank pin's input passed through two flops, ANDed with its input enable; bits [31:16] read 0. A change on pin_in shows up after the second rising edge.
- R7: pin_oe is high only when output enable is 1 and the pin is not open-drain with level 1. pin_out equals the output level, forced to 0 when open-drain is set.
- R8: pin_pu and pin_pd follow the stored pull-up and pull-down bits.
- R9: Every other offset reads as 0, including 0x00, 0x30 on write, and unaligned offsets. Writes to those offsets change nothing.
- R10: While rst_n is low, all stored bits and all outputs are 0. Internal reset release follows the rising edge of rst_n by two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Byte offset in the register window |
| bus_wdata | input | 32 | Write word: set mask [15:0], clear mask [31:16] |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pin_in | input | 32 | Pin input levels (asynchronous) |
| pin_out | output | 32 | Pin drive level |
| pin_oe | output | 32 | Pin drive enable |
| pin_pu | output | 32 | Pull-up enable per pin |
| pin_pd | output | 32 | Pull-down enable per pin |

## Verification
The properties assume that no write arrives during the two cycles in which the internal reset is still held after rst_n rises. They also assume that bus_wr is a single-cycle strobe sampled on the rising edge. The bench waits several cycles after reset before the first write, and it changes the bus inputs and pin_in only on falling edges. Its stimulus mixes random set and clear masks, including words that set and clear the same pin, with writes to unmapped offsets and random pin levels. Directed cases cover the bank split, clear priority and the two-edge input latency.

// File: rtl/gpio_atomic_pkg.sv
package gpio_atomic_pkg;
  localparam int DATA_W   = 32;
  localparam int HALF_W   = DATA_W / 2;
  localparam int OFF_W    = 7;
  localparam int NUM_FEAT = 6;

  typedef enum logic [2:0] {
    FEAT_LVL = 3'd0,
    FEAT_OE  = 3'd1,
    FEAT_OD  = 3'd2,
    FEAT_PU  = 3'd3,
    FEAT_PD  = 3'd4,
    FEAT_IE  = 3'd5
  } feat_e;

  localparam logic [OFF_W-1:0] OFF_LVL = 7'h00;
  localparam logic [OFF_W-1:0] OFF_OE  = 7'h04;
  localparam logic [OFF_W-1:0] OFF_OD  = 7'h08;
  localparam logic [OFF_W-1:0] OFF_PU  = 7'h18;
  localparam logic [OFF_W-1:0] OFF_PD  = 7'h1C;
  localparam logic [OFF_W-1:0] OFF_IE  = 7'h20;
  localparam logic [OFF_W-1:0] OFF_IN  = 7'h30;

  function automatic logic [OFF_W-1:0] feat_offset(input int unsigned f);
    case (f)
      0:       feat_offset = OFF_LVL;
      1:       feat_offset = OFF_OE;
      2:       feat_offset = OFF_OD;
      3:       feat_offset = OFF_PU;
      4:       feat_offset = OFF_PD;
      default: feat_offset = OFF_IE;
    endcase
  endfunction
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_setclr_reg.sv
module gpio_setclr_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] set_mask,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] q
);
  logic [W-1:0] state_q;
  logic [W-1:0] state_d;

  // the clear mask is applied after the set mask, so clear has priority
  always_comb begin
    state_d = state_q;
    if (wr_en) state_d = (state_q | set_mask) & ~clr_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     state_q <= '0;
    else if (wr_en) state_q <= state_d;
  end

  assign q = state_q;
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] stage_d [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        assign stage_d[s] = d;
      end else begin : g_next
        assign stage_d[s] = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_d[s];
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_atomic_pkg::*;
#(
  parameter int W           = HALF_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sel_wr,
  input  logic [OFF_W-1:0] off,
  input  logic [2*W-1:0] wdata,
  input  logic [W-1:0]   pad_in,
  output logic [2*W-1:0] rdata,
  output logic [W-1:0]   pad_out,
  output logic [W-1:0]   pad_oe,
  output logic [W-1:0]   pad_pu,
  output logic [W-1:0]   pad_pd
);
  logic [W-1:0]        feat_q [NUM_FEAT];
  logic [NUM_FEAT-1:0] feat_wr;
  logic [W-1:0]        in_sync;
  logic [W-1:0]        lvl_rb;

  genvar f;
  generate
    for (f = 0; f < NUM_FEAT; f++) begin : g_feat
      assign feat_wr[f] = sel_wr && (off == feat_offset(f));
      gpio_setclr_reg #(.W(W)) u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (feat_wr[f]),
        .set_mask (wdata[W-1:0]),
        .clr_mask (wdata[2*W-1:W]),
        .q        (feat_q[f])
      );
    end
  endgenerate

  gpio_in_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_in),
    .q     (in_sync)
  );

  assign lvl_rb = in_sync & feat_q[FEAT_IE];

  always_comb begin
    rdata = '0;
    case (off)
      OFF_OE:  rdata = {~feat_q[FEAT_OE], feat_q[FEAT_OE]};
      OFF_OD:  rdata = {~feat_q[FEAT_OD], feat_q[FEAT_OD]};
      OFF_PU:  rdata = {~feat_q[FEAT_PU], feat_q[FEAT_PU]};
      OFF_PD:  rdata = {~feat_q[FEAT_PD], feat_q[FEAT_PD]};
      OFF_IE:  rdata = {~feat_q[FEAT_IE], feat_q[FEAT_IE]};
      OFF_IN:  rdata = {{W{1'b0}}, lvl_rb};
      default: rdata = '0;
    endcase
  end

  // open-drain pins only ever pull low: a level of 1 releases the pad
  assign pad_out = feat_q[FEAT_LVL] & ~feat_q[FEAT_OD];
  assign pad_oe  = feat_q[FEAT_OE] & ~(feat_q[FEAT_OD] & feat_q[FEAT_LVL]);
  assign pad_pu  = feat_q[FEAT_PU];
  assign pad_pd  = feat_q[FEAT_PD];
endmodule

// File: rtl/gpio_atomic_ctrl.sv
module gpio_atomic_ctrl
  import gpio_atomic_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic [31:0] pin_in,
  output logic [31:0] pin_out,
  output logic [31:0] pin_oe,
  output logic [31:0] pin_pu,
  output logic [31:0] pin_pd
);
  localparam int NUM_BANKS = 2;
  localparam int PPB       = HALF_W;

  logic              rst_n_int;
  logic [DATA_W-1:0] bank_rd [NUM_BANKS];
  logic              bank_sel;

  gpio_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  assign bank_sel = bus_addr[7];

  genvar b;
  generate
    for (b = 0; b < NUM_BANKS; b++) begin : g_bank
      gpio_bank #(.W(PPB), .SYNC_STAGES(SYNC_STAGES)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n_int),
        .sel_wr  (bus_wr && (bank_sel == b[0])),
        .off     (bus_addr[OFF_W-1:0]),
        .wdata   (bus_wdata),
        .pad_in  (pin_in[b*PPB +: PPB]),
        .rdata   (bank_rd[b]),
        .pad_out (pin_out[b*PPB +: PPB]),
        .pad_oe  (pin_oe[b*PPB +: PPB]),
        .pad_pu  (pin_pu[b*PPB +: PPB]),
        .pad_pd  (pin_pd[b*PPB +: PPB])
      );
    end
  endgenerate

  assign bus_rdata = bank_rd[bank_sel];
endmodule

// File: rtl/gpio_atomic_ctrl_chk.sv
module gpio_atomic_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic [7:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic [31:0] pin_oe,
  input logic [31:0] pin_out,
  input logic [31:0] pin_pu,
  input logic [31:0] pin_pd
);
  logic feat_rd;
  logic mapped_rd;

  always_comb begin
    feat_rd = (bus_addr[6:0] == 7'h04) || (bus_addr[6:0] == 7'h08) ||
              (bus_addr[6:0] == 7'h18) || (bus_addr[6:0] == 7'h1C) ||
              (bus_addr[6:0] == 7'h20);
    mapped_rd = feat_rd || (bus_addr[6:0] == 7'h30);
  end

  genvar n;
  generate
    for (n = 0; n < 32; n++) begin : g_pin
      localparam logic [7:0] BASE = (n >= 16) ? 8'h80 : 8'h00;
      localparam int K = n % 16;

      p_clear_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == (BASE | 8'h04) && bus_wdata[K+16]) |=> !pin_oe[n]);

      p_set_pullup_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == (BASE | 8'h18) && bus_wdata[K] && !bus_wdata[K+16])
        |=> pin_pu[n]);
    end
  endgenerate

  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> ($stable(pin_pu) && $stable(pin_pd) && $stable(pin_oe) && $stable(pin_out)));

  p_complement_r5: assert property (@(posedge clk) disable iff (!rst_n)
    feat_rd |-> (bus_rdata[31:16] == ~bus_rdata[15:0]));

  p_level_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[6:0] == 7'h30) |-> (bus_rdata[31:16] == 16'h0));

  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped_rd |-> (bus_rdata == 32'h0));

  p_od_no_high_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 8'h08 && bus_wdata[0] && !bus_wdata[16]) |=> !pin_out[0]);
endmodule

bind gpio_atomic_ctrl gpio_atomic_ctrl_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pin_oe    (pin_oe),
  .pin_out   (pin_out),
  .pin_pu    (pin_pu),
  .pin_pd    (pin_pd)
);

// File: tb/gpio_atomic_ctrl_tb_top.sv
`timescale 1ns/10ps
module gpio_atomic_ctrl_tb_top;
  logic        clk;
  logic        rst_n;
  logic        bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in;
  logic [31:0] pin_out, pin_oe, pin_pu, pin_pd;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // model state, one 32-bit vector per feature across both banks
  logic [31:0] m_lvl, m_oe, m_od, m_pu, m_pd, m_ie;
  logic [31:0] m_s1, m_s2;

  gpio_atomic_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu), .pin_pd(pin_pd)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // R6: two-edge input latency model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= '0;
      m_s2 <= '0;
    end else begin
      m_s1 <= pin_in;
      m_s2 <= m_s1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] upd(input logic [31:0] cur, input int bk, input logic [31:0] d);
    logic [31:0] r = cur;
    r[bk*16 +: 16] = (cur[bk*16 +: 16] | d[15:0]) & ~d[31:16];
    return r;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [7:0] a);
    int bk = int'(a[7]);
    logic [15:0] v;
    case (a[6:0])
      7'h04: begin v = m_oe[bk*16 +: 16]; return {~v, v}; end
      7'h08: begin v = m_od[bk*16 +: 16]; return {~v, v}; end
      7'h18: begin v = m_pu[bk*16 +: 16]; return {~v, v}; end
      7'h1C: begin v = m_pd[bk*16 +: 16]; return {~v, v}; end
      7'h20: begin v = m_ie[bk*16 +: 16]; return {~v, v}; end
      7'h30: begin v = m_s2[bk*16 +: 16] & m_ie[bk*16 +: 16]; return {16'h0, v}; end
      default: return 32'h0;
    endcase
  endfunction

  task automatic apply_model(input logic [7:0] a, input logic [31:0] d);
    int bk = int'(a[7]);
    case (a[6:0])
      7'h00: m_lvl = upd(m_lvl, bk, d);
      7'h04: m_oe  = upd(m_oe, bk, d);
      7'h08: m_od  = upd(m_od, bk, d);
      7'h18: m_pu  = upd(m_pu, bk, d);
      7'h1C: m_pd  = upd(m_pd, bk, d);
      7'h20: m_ie  = upd(m_ie, bk, d);
      default: ;
    endcase
  endtask

  task automatic do_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    apply_model(a, d);
    @(negedge clk);
    bus_wr = 1'b0;
    #0.1;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    bus_addr = a;
    #0.1;
    v = bus_rdata;
  endtask

  task automatic check_all();
    logic [7:0] offs [9] = '{8'h00, 8'h04, 8'h08, 8'h18, 8'h1C, 8'h20, 8'h30, 8'h0C, 8'h31};
    logic [31:0] v;
    chk("R7 pin_oe",  pin_oe,  m_oe & ~(m_od & m_lvl));
    chk("R7 pin_out", pin_out, m_lvl & ~m_od);
    chk("R8 pin_pu",  pin_pu,  m_pu);
    chk("R8 pin_pd",  pin_pd,  m_pd);
    for (int bk = 0; bk < 2; bk++) begin
      for (int i = 0; i < 9; i++) begin
        logic [7:0] a = offs[i] | (bk == 1 ? 8'h80 : 8'h00);
        rd(a, v);
        if (i >= 1 && i <= 5) chk("R5 feature read", v, exp_rd(a));
        else if (i == 6)      chk("R6 level read", v, exp_rd(a));
        else                  chk("R9 unmapped read", v, exp_rd(a));
      end
    end
  endtask

  initial begin
    #(4.0 * 150000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [7:0] unm [7] = '{8'h30, 8'h0C, 8'h10, 8'h24, 8'h05, 8'h7C, 8'h40};
    logic [7:0] fo [6] = '{8'h00, 8'h04, 8'h08, 8'h18, 8'h1C, 8'h20};
    void'($urandom(32'd4242));
    rst_n = 1'b1; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; pin_in = '0;
    {m_lvl, m_oe, m_od, m_pu, m_pd, m_ie} = '0;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R10: state during reset
    chk("R10 pin_oe in reset", pin_oe, 32'h0);
    chk("R10 pin_pu in reset", pin_pu, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #0.1;
    rd(8'h04, v); chk("R10 oe after reset", v, 32'hFFFF_0000);
    check_all();

    // R1: high bank is at 0x80
    do_write(8'h98, 32'h0000_0001);
    chk("R1 high bank pull-up", pin_pu, 32'h0001_0000);
    rd(8'h18, v); chk("R1 low bank untouched", v, 32'hFFFF_0000);
    // R2: set
    do_write(8'h18, 32'h0000_8001);
    chk("R2 set pull-up", pin_pu, 32'h0001_8001);
    // R3: set and clear together on pin 0, clear wins
    do_write(8'h18, 32'h0001_0001);
    chk("R3 clear wins", pin_pu, 32'h0001_8000);
    // R4: empty write keeps state
    do_write(8'h18, 32'h0000_0000);
    chk("R4 empty write", pin_pu, 32'h0001_8000);
    // R9: write to read-back and unaligned offsets is ignored
    do_write(8'h30, 32'h0000_FFFF);
    do_write(8'h19, 32'h0000_FFFF);
    chk("R9 ignored writes", pin_pu, 32'h0001_8000);
    // R7: open-drain with level 1 releases the pad
    do_write(8'h04, 32'h0000_0003);
    do_write(8'h00, 32'h0000_0003);
    do_write(8'h08, 32'h0000_0001);
    chk("R7 od drive enable", pin_oe, 32'h0000_0002);
    chk("R7 od drive level", pin_out, 32'h0000_0002);
    check_all();

    // R6: latency and gating
    do_write(8'h20, 32'h0000_FFFF);
    @(negedge clk); pin_in = 32'h0000_00A5;
    @(negedge clk); #0.1; rd(8'h30, v); chk("R6 one edge", v, 32'h0000_0000);
    @(negedge clk); #0.1; rd(8'h30, v); chk("R6 two edges", v, 32'h0000_00A5);
    do_write(8'h20, 32'h0001_0000);
    rd(8'h30, v); chk("R6 gated by input enable", v, 32'h0000_00A4);
    rd(8'hB0, v); chk("R6 high bank disabled", v, 32'h0);
    check_all();

    // random phase
    for (int it = 0; it < 400; it++) begin
      int op = int'($urandom_range(0, 9));
      logic [31:0] d = $urandom();
      logic [7:0] bank = ($urandom_range(0, 1) == 1) ? 8'h80 : 8'h00;
      if (($urandom_range(0, 3)) == 0) d[31:16] = d[31:16] & d[15:0];
      if (op < 7)
        do_write(bank | fo[$urandom_range(0, 5)], d);
      else if (op < 8)
        do_write(bank | unm[$urandom_range(0, 6)], d);
      else begin
        @(negedge clk); pin_in = $urandom();
        @(negedge clk); #0.1;
      end
      check_all();
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule